// File: doc/BRIEF.md
# Ethernet Pause Frame Trigger Controller

This block decides when a MAC transmitter has to emit flow-control PAUSE frames. A level from the receive buffering logic says when the local side wants the link partner to stop. When that level rises while no pause is in force, the block asks the transmitter for a PAUSE frame. The frame carries the configured pause duration in slot times, where one slot time is 512 bit times (64 bytes). The request is a level with a quanta value. It is held until the transmitter returns a one-cycle done pulse, and only one request is outstanding at any time.

After each acknowledged pause frame, a timer counts slot-time ticks. The timer stops at a recheck point, which is the pause duration minus an offset chosen by a 2-bit select. If flow control is still asserted at that point, a fresh pause frame is requested before the partner's pause runs out. When flow control is released, a pause frame with zero quanta is requested so that the partner resumes at once. A configuration bit can suppress this zero-quanta frame.

The configured pause duration is taken into an internal copy no more often than once every four clock cycles. This suits a value that crosses from a slower configuration domain.

Top module: `pause_trigger`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `frameReq` is 0 and `frameQuanta` is 0, and no pause is active.
- R2: When `flowCtrl` is high, no pause is active and no request is pending, `frameReq` rises on the next clock edge with `frameQuanta` equal to the captured pause duration.
- R3: Once raised, `frameReq` stays high with an unchanged `frameQuanta` until a cycle in which `txDone` is high. It falls on the edge that samples `txDone`, and at most one request is outstanding.
- R4: The `txDone` that acknowledges a non-zero frame restarts the timer from zero. The timer then advances by one for each cycle in which `slotTick` is high.
- R5: The recheck point is the pause duration minus 4, 28, 144 or 256 for `cfgThreshSel` values 0, 1, 2 and 3. When the timer equals that point and `flowCtrl` is still high, a new request carrying the pause duration is raised on the next edge.
- R6: If the selected offset is not below the pause duration, the recheck point is 0. A refresh request then follows one cycle after the acknowledge while `flowCtrl` stays high.
- R7: A falling edge of `flowCtrl` during an active pause, with no request pending and `cfgNoZeroQuanta` = 0, raises `frameReq` on the next edge with `frameQuanta` = 0.
- R8: With `cfgNoZeroQuanta` = 1, releasing `flowCtrl` ends the pause without any frame request. A later rise of `flowCtrl` starts a new pause at once.
- R9: If `flowCtrl` falls while a non-zero request is pending, that request is kept unchanged. The zero-quanta request is raised one cycle after its acknowledge.
- R10: A change of `cfgPauseTime` is captured at most once in any four consecutive cycles. A second change inside that window takes effect only after the window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgPauseTime | input | 16 | Pause duration in slot times |
| cfgThreshSel | input | 2 | Recheck offset select (0:4, 1:28, 2:144, 3:256) |
| cfgNoZeroQuanta | input | 1 | Suppresses the zero-quanta frame on release |
| slotTick | input | 1 | One-cycle pulse per elapsed slot time |
| flowCtrl | input | 1 | Flow-control request level from the receive buffer |
| txDone | input | 1 | Transmitter pulse: the requested frame was sent |
| frameReq | output | 1 | Pause frame request, held until `txDone` |
| frameQuanta | output | 16 | Quanta value for the requested frame |

## Verification
On every cycle the assertions check four things. They check that a pending request holds with a stable quanta value, and that the control never issues two kinds of request at once. They also check that the timer only resets to zero or steps by one on a tick, and that a newly captured pause duration stays in place for the following three cycles. Other behaviours can only be shown by the bench's scenarios. These are the exact tick counts at which each of the four recheck points fires, the zero-quanta frame on release, and its deferral behind a pending frame. The same holds for its suppression by the configuration bit, the saturated recheck point, and which of two quick duration writes ends up in a frame.

// File: rtl/pause_trigger_pkg.sv
package pause_trigger_pkg;

  typedef struct packed {
    logic issuePause;  // load configured duration into the frame quanta
    logic issueZero;   // load zero into the frame quanta
    logic clearTimer;  // restart the slot-time counter
    logic stepTimer;   // advance the slot-time counter
  } ctrlStrobes_t;

  function automatic int unsigned threshOffset(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4;
      2'd1:    return 28;
      2'd2:    return 144;
      default: return 256;
    endcase
  endfunction

endpackage

// File: rtl/pause_trigger_dp.sv
module pause_trigger_dp
  import pause_trigger_pkg::*;
#(
  parameter int PT_W        = 16,
  parameter int HOLD_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PT_W-1:0] cfgPauseTime,
  input  logic [1:0]      cfgThreshSel,
  input  ctrlStrobes_t    str,
  output logic            atThresh,
  output logic [PT_W-1:0] quanta
);

  localparam int HC_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [HC_W-1:0] HOLD_RELOAD = HC_W'(HOLD_CYCLES - 1);

  logic [PT_W-1:0] ptShadow;
  logic [HC_W-1:0] holdCnt;
  logic [PT_W-1:0] timer;
  logic [PT_W-1:0] offsetVal;
  logic [PT_W-1:0] threshPoint;

  // Captured duration, spaced at least HOLD_CYCLES cycles between updates
  always_ff @(posedge clk) begin
    if (rst) begin
      ptShadow <= '0;
      holdCnt  <= '0;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end else if (cfgPauseTime != ptShadow) begin
      ptShadow <= cfgPauseTime;
      holdCnt  <= HOLD_RELOAD;
    end
  end

  always_comb begin
    offsetVal   = PT_W'(threshOffset(cfgThreshSel));
    threshPoint = (ptShadow > offsetVal) ? (ptShadow - offsetVal) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || str.clearTimer) timer <= '0;
    else if (str.stepTimer)    timer <= timer + 1'b1;
  end

  assign atThresh = (timer == threshPoint);

  always_ff @(posedge clk) begin
    if (rst)                 quanta <= '0;
    else if (str.issuePause) quanta <= ptShadow;
    else if (str.issueZero)  quanta <= '0;
  end

  // R10: a fresh capture stays in place for the following three cycles
  p_cfg_spacing_r10: assert property (@(posedge clk) disable iff (rst)
    (ptShadow != $past(ptShadow)) |=> $stable(ptShadow) ##1 $stable(ptShadow) ##1 $stable(ptShadow))
    else $error("R10: pause duration captured too often");

  // R4: the timer only restarts at zero or steps by one on a step strobe
  p_timer_step_r4: assert property (@(posedge clk) disable iff (rst)
    (timer != $past(timer)) |-> (timer == '0) || ($past(str.stepTimer) && timer == $past(timer) + 1'b1))
    else $error("R4: timer moved without a slot tick");

endmodule

// File: rtl/pause_trigger_ctrl.sv
module pause_trigger_ctrl
  import pause_trigger_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         cfgNoZeroQuanta,
  input  logic         slotTick,
  input  logic         flowCtrl,
  input  logic         txDone,
  input  logic         atThresh,
  output ctrlStrobes_t str,
  output logic         reqValid
);

  logic flowPrev;
  logic pauseActive;
  logic zeroOwed;
  logic pendZero;
  logic timing;

  logic fallEvt, doneEvt, zeroNow, startNow, refreshNow;

  always_comb begin
    fallEvt    = flowPrev && !flowCtrl && pauseActive;
    doneEvt    = txDone && reqValid;
    zeroNow    = (zeroOwed || (fallEvt && !cfgNoZeroQuanta)) && !reqValid;
    startNow   = flowCtrl && !pauseActive && !reqValid && !zeroNow;
    refreshNow = timing && atThresh && flowCtrl && pauseActive && !reqValid && !zeroOwed;

    str.issuePause = startNow || refreshNow;
    str.issueZero  = zeroNow;
    str.clearTimer = doneEvt && !pendZero;
    str.stepTimer  = timing && slotTick && !atThresh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flowPrev    <= 1'b0;
      pauseActive <= 1'b0;
      zeroOwed    <= 1'b0;
      pendZero    <= 1'b0;
      timing      <= 1'b0;
      reqValid    <= 1'b0;
    end else begin
      flowPrev <= flowCtrl;

      if (str.issuePause || str.issueZero) begin
        reqValid <= 1'b1;
        pendZero <= str.issueZero;
      end else if (doneEvt) begin
        reqValid <= 1'b0;
      end

      if (str.issuePause)
        pauseActive <= 1'b1;
      else if ((fallEvt && cfgNoZeroQuanta) || (doneEvt && pendZero))
        pauseActive <= 1'b0;

      if (zeroNow)
        zeroOwed <= 1'b0;
      else if (fallEvt && !cfgNoZeroQuanta && reqValid)
        zeroOwed <= 1'b1;

      if (fallEvt || refreshNow)
        timing <= 1'b0;
      else if (doneEvt && !pendZero)
        timing <= flowCtrl;
    end
  end

  // R3: never two kinds of request issued in one cycle
  p_single_issue_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({str.issuePause, str.issueZero}))
    else $error("R3: conflicting request strobes");

endmodule

// File: rtl/pause_trigger.sv
module pause_trigger
  import pause_trigger_pkg::*;
#(
  parameter int PT_W        = 16,
  parameter int HOLD_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PT_W-1:0] cfgPauseTime,
  input  logic [1:0]      cfgThreshSel,
  input  logic            cfgNoZeroQuanta,
  input  logic            slotTick,
  input  logic            flowCtrl,
  input  logic            txDone,
  output logic            frameReq,
  output logic [PT_W-1:0] frameQuanta
);

  ctrlStrobes_t str;
  logic         atThresh;

  pause_trigger_ctrl u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .cfgNoZeroQuanta (cfgNoZeroQuanta),
    .slotTick        (slotTick),
    .flowCtrl        (flowCtrl),
    .txDone          (txDone),
    .atThresh        (atThresh),
    .str             (str),
    .reqValid        (frameReq)
  );

  pause_trigger_dp #(
    .PT_W        (PT_W),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .cfgPauseTime (cfgPauseTime),
    .cfgThreshSel (cfgThreshSel),
    .str          (str),
    .atThresh     (atThresh),
    .quanta       (frameQuanta)
  );

  // R3: a pending request holds with a stable value until acknowledged
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (frameReq && !txDone) |=> (frameReq && $stable(frameQuanta)))
    else $error("R3: request dropped or changed before done");

endmodule

// File: tb/test_pause_trigger.sv
`timescale 1ns/1ps
module test_pause_trigger;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfgPauseTime = 16'd40;
  logic [1:0]  cfgThreshSel = 2'd0;
  logic        cfgNoZeroQuanta = 1'b0;
  logic        slotTick = 1'b0;
  logic        flowCtrl = 1'b0;
  logic        txDone = 1'b0;
  logic        frameReq;
  logic [15:0] frameQuanta;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;
  int unsigned expQ[$];
  logic prevReq = 1'b0;

  always #2 clk = ~clk;

  pause_trigger i_pause_trigger (
    .clk(clk), .rst(rst), .cfgPauseTime(cfgPauseTime), .cfgThreshSel(cfgThreshSel),
    .cfgNoZeroQuanta(cfgNoZeroQuanta), .slotTick(slotTick), .flowCtrl(flowCtrl),
    .txDone(txDone), .frameReq(frameReq), .frameQuanta(frameQuanta)
  );

  task automatic check(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      slotTick = 1'b1; @(negedge clk);
      slotTick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic ack();
    txDone = 1'b1; @(negedge clk);
    txDone = 1'b0;
  endtask

  task automatic expectFrame(input int unsigned q);
    expQ.push_back(q);
  endtask

  // Monitor: every new request is popped against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (frameReq && !prevReq) begin
        if (expQ.size() == 0) check(1'b0, "R3 unexpected request", frameQuanta, 0);
        else begin
          int unsigned e;
          e = expQ.pop_front();
          check(frameQuanta == e, "R2/R5/R7 frame quanta", frameQuanta, e);
        end
      end
      prevReq = frameReq;
    end
  end

  initial begin
    cyc(2);
    check(frameReq == 1'b0, "R1 req in reset", frameReq, 0);
    check(frameQuanta == 0, "R1 quanta in reset", frameQuanta, 0);
    rst = 1'b0;
    cyc(1);
    check(frameReq == 1'b0, "R1 req after reset", frameReq, 0);
    cyc(5);

    // R2 / R3: start and hold
    expectFrame(40); flowCtrl = 1'b1; cyc(1);
    check(frameReq == 1'b1, "R2 start request", frameReq, 1);
    check(frameQuanta == 40, "R2 start quanta", frameQuanta, 40);
    cyc(5);
    check(frameReq == 1'b1 && frameQuanta == 40, "R3 held until done", frameQuanta, 40);
    ack();
    check(frameReq == 1'b0, "R3 drop on done", frameReq, 0);

    // R4 / R5 select 0: 40-4 = 36
    tick(35);
    check(frameReq == 1'b0, "R5 sel0 before point", frameReq, 0);
    expectFrame(40); tick(1);
    check(frameReq == 1'b1, "R5 sel0 at point", frameReq, 1);
    ack();
    // select 1: 40-28 = 12, timer restarted at done (R4)
    cfgThreshSel = 2'd1;
    tick(11);
    check(frameReq == 1'b0, "R4 R5 sel1 before point", frameReq, 0);
    expectFrame(40); tick(1);
    check(frameReq == 1'b1, "R5 sel1 at point", frameReq, 1);
    ack();

    // R7: release gives a zero-quanta frame
    expectFrame(0); flowCtrl = 1'b0; cyc(1);
    check(frameReq == 1'b1 && frameQuanta == 0, "R7 zero request", frameQuanta, 0);
    ack();
    check(frameReq == 1'b0, "R7 zero acknowledged", frameReq, 0);

    // R5 selects 2 and 3 with duration 300: points 156 and 44
    cfgPauseTime = 16'd300; cfgThreshSel = 2'd2; cyc(6);
    expectFrame(300); flowCtrl = 1'b1; cyc(1); ack();
    tick(155);
    check(frameReq == 1'b0, "R5 sel2 before point", frameReq, 0);
    expectFrame(300); tick(1);
    check(frameReq == 1'b1, "R5 sel2 at point", frameReq, 1);
    ack();
    cfgThreshSel = 2'd3;
    tick(43);
    check(frameReq == 1'b0, "R5 sel3 before point", frameReq, 0);
    expectFrame(300); tick(1);
    check(frameReq == 1'b1, "R5 sel3 at point", frameReq, 1);
    ack();

    // R9: release while a refresh is pending
    expectFrame(300); tick(44);
    flowCtrl = 1'b0; cyc(3);
    check(frameReq == 1'b1 && frameQuanta == 300, "R9 pending kept", frameQuanta, 300);
    expectFrame(0); ack();
    check(frameReq == 1'b0, "R9 gap after done", frameReq, 0);
    cyc(1);
    check(frameReq == 1'b1 && frameQuanta == 0, "R9 zero after done", frameQuanta, 0);
    ack();

    // R8: zero-quanta suppressed
    cfgNoZeroQuanta = 1'b1;
    expectFrame(300); flowCtrl = 1'b1; cyc(1); ack();
    flowCtrl = 1'b0; cyc(4);
    check(frameReq == 1'b0, "R8 no zero frame", frameReq, 0);
    expectFrame(300); flowCtrl = 1'b1; cyc(1);
    check(frameReq == 1'b1 && frameQuanta == 300, "R8 restart after release", frameQuanta, 300);
    ack(); flowCtrl = 1'b0; cyc(2);
    check(frameReq == 1'b0, "R8 second release silent", frameReq, 0);
    cfgNoZeroQuanta = 1'b0;

    // R6: offset 144 not below 20 gives point 0
    cfgPauseTime = 16'd20; cfgThreshSel = 2'd2; cyc(6);
    expectFrame(20); flowCtrl = 1'b1; cyc(1);
    expectFrame(20); ack();
    check(frameReq == 1'b0, "R6 idle right after done", frameReq, 0);
    cyc(1);
    check(frameReq == 1'b1 && frameQuanta == 20, "R6 immediate refresh", frameQuanta, 20);
    flowCtrl = 1'b0; cyc(1);
    expectFrame(0); ack(); cyc(1);
    check(frameReq == 1'b1 && frameQuanta == 0, "R6 R9 zero after refresh", frameQuanta, 0);
    ack(); cyc(2);

    // R10: two quick writes, the second one is deferred
    cfgPauseTime = 16'd100; cyc(1);
    cfgPauseTime = 16'd200; expectFrame(100); flowCtrl = 1'b1; cyc(1);
    check(frameQuanta == 100, "R10 first write used", frameQuanta, 100);
    ack();
    expectFrame(0); flowCtrl = 1'b0; cyc(1); ack(); cyc(4);
    expectFrame(200); flowCtrl = 1'b1; cyc(1);
    check(frameQuanta == 200, "R10 second write later", frameQuanta, 200);
    ack();
    expectFrame(0); flowCtrl = 1'b0; cyc(1); ack(); cyc(3);

    check(expQ.size() == 0, "R3 all expected frames seen", expQ.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule